// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block puts one low-speed USB packet on the D+ and D- lines. The block drives the lines and their output enable. A start strobe begins a packet. The packet is either a data packet, whose bytes arrive on a ready/valid byte port, or a handshake (ACK or NAK), whose single PID byte the block supplies itself. The block always sends the sync byte first and counts it in the byte count. It sends each byte least significant bit first, NRZI-codes the bit stream and inserts stuffed bits. It ends the packet with an end-of-packet sequence and then releases the bus.

The block does not compute a CRC, assemble packets or decide when to answer a received packet; the start strobe is its only timing input. After a data packet has been sent in full, it gives a one-cycle pulse. A pending device address may be made active at that pulse. If the byte source falls behind in the middle of a packet, the packet is cut short with an end-of-packet sequence and an error flag is set.

The controller has five states. IDLE leaves the bus released. LEAD drives J for one bit. DATA sends the coded bits. SE0 drives both lines low. EOPJ drives the closing J. The transitions are:
- begin: IDLE to LEAD on an accepted start.
- launch: LEAD to DATA at the end of the bit.
- finish: DATA to SE0 when the last bit and any pending stuffed bit have gone out.
- abort: DATA to SE0 on an underrun.
- close: SE0 to EOPJ after two bit times.
- release: EOPJ to IDLE after one bit time.

Top module: `lsusb_tx`

## Requirements
- R1: During and right after reset, oe_o, dp_o, dm_o, busy, in_ready, tx_err and addr_commit are all 0.
- R2: A start that is sampled while the block is idle makes oe_o high with the lines at J (dp_o=0, dm_o=1) from the next cycle. J holds for one bit time, so the first coded bit begins CLKS_PER_BIT+1 cycles after the start edge. This is well inside a 7.5-bit turnaround budget.
- R3: The first byte sent is the sync byte 0x80, and every byte goes out least significant bit first. byte_cnt counts the sync byte, so a data packet carries byte_cnt-1 bytes from the byte port. A byte_cnt of 0 is treated as 1.
- R4: The line coding is NRZI. A 0 bit toggles the line between J and K (K is dp_o=1, dm_o=0), and a 1 bit keeps the current state. dp_o and dm_o are never both high.
- R5: After STUFF_RUN (6) consecutive 1 bits, counted across byte boundaries, one extra toggle is inserted. The run count restarts after a stuffed toggle and after every real 0. A stuffed toggle that falls due after the final byte is still sent before the end of packet.
- R6: Every bit, including the lead J and the end-of-packet bits, lasts CLKS_PER_BIT clocks, and the lines do not change inside a bit.
- R7: in_ready is high for exactly one clock, the last clock of the bit before a data byte's first bit. A byte is taken when in_valid is also high in that clock.
- R8: With hs_req high at start, the block sends sync plus PID 0xD2 (ACK, hs_nak=0) or 0x5A (NAK, hs_nak=1). In this case byte_cnt and the byte port are ignored, and in_ready stays low.
- R9: After the last bit, the block drives SE0 for two bit times, then J for one bit time, and then drops oe_o.
- R10: busy is high from the cycle after an accepted start until the cycle in which oe_o drops.
- R11: addr_commit pulses for one cycle, in the cycle oe_o drops, only after a data packet that completed. It does not pulse after a handshake or an aborted packet.
- R12: If in_valid is low while in_ready is high, the block skips the rest of the packet: the next bit is SE0 and the R9 sequence follows. tx_err is set at that point and stays set until the next accepted start clears it.
- R13: A start that arrives while busy is high has no effect on the packet in flight or on the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, CLKS_PER_BIT clocks per bit |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| start | input | 1 | Begin a packet; accepted only when idle |
| hs_req | input | 1 | With start: send a handshake instead of a data packet |
| hs_nak | input | 1 | Handshake kind: 0 = ACK, 1 = NAK |
| byte_cnt | input | CNT_W | Bytes in a data packet including the sync byte |
| in_data | input | 8 | Next data byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Byte taken this clock when in_valid is high |
| dp_o | output | 1 | D+ line level |
| dm_o | output | 1 | D- line level |
| oe_o | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress |
| tx_err | output | 1 | Last packet was aborted by an underrun |
| addr_commit | output | 1 | One-cycle pulse: a pending address may become active |

## Verification
The two functions that can fall in the same bit are a stuffed bit and the fetch of the next byte. This happens when a byte ends with six 1 bits. The stuffed toggle must take that bit slot, and in_ready must move one bit later. The same clash at the end of a packet must put the stuffed bit ahead of SE0. Both cases are provoked with the byte 0xFC, once in the middle of a packet and once as its last byte. They are judged against a bit-by-bit line sequence that the bench builds independently, sampled in the middle of every bit.

// File: rtl/lstx_pkg.sv
package lstx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_DATA,
        ST_SE0,
        ST_EOPJ
    } lstx_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;

endpackage

// File: rtl/lstx_bit_timer.sv
module lstx_bit_timer #(
    parameter int CLKS_PER_BIT = 8,
    localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    output logic            tick,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] LAST = PH_W'(CLKS_PER_BIT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign tick = run && (phase == LAST);

endmodule

// File: rtl/lstx_nrzi_stuff.sv
module lstx_nrzi_stuff #(
    parameter int STUFF_RUN = 6,
    localparam int OW = $clog2(STUFF_RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic step,
    input  logic bit_in,
    output logic level_k,
    output logic stuff_due
);

    logic [OW-1:0] ones;

    assign stuff_due = (ones == OW'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            level_k <= 1'b0;
            ones    <= '0;
        end else if (step) begin
            if (stuff_due || !bit_in) begin
                level_k <= ~level_k;
                ones    <= '0;
            end else begin
                ones    <= ones + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
    import lstx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int STUFF_RUN    = 6,
    parameter int CNT_W        = 8,
    parameter int EOP_SE0_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hs_req,
    input  logic             hs_nak,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             dp_o,
    output logic             dm_o,
    output logic             oe_o,
    output logic             busy,
    output logic             tx_err,
    output logic             addr_commit
);

    localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int SE_W = (EOP_SE0_BITS > 1) ? $clog2(EOP_SE0_BITS) : 1;

    lstx_state_e      state, state_nx;
    logic [7:0]       shreg, pid_byte, next_byte;
    logic [2:0]       bits_left;
    logic [CNT_W-1:0] bytes_left;
    logic [SE_W-1:0]  se0_cnt;
    logic             hs_mode;
    logic             tick, accept, level_k, stuff_due;
    logic             need_byte, pkt_done, underrun, load_byte;
    logic             coder_step, coder_bit;
    logic [PH_W-1:0]  bit_phase;

    assign accept = start && (state == ST_IDLE);

    lstx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (state != ST_IDLE),
        .tick  (tick),
        .phase (bit_phase)
    );

    lstx_nrzi_stuff #(.STUFF_RUN(STUFF_RUN)) u_coder (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (accept),
        .step      (coder_step),
        .bit_in    (coder_bit),
        .level_k   (level_k),
        .stuff_due (stuff_due)
    );

    // bit-boundary decisions
    assign need_byte = (state == ST_DATA) && tick && !stuff_due
                    && (bits_left == 3'd0) && (bytes_left != '0);
    assign pkt_done  = (state == ST_DATA) && tick && !stuff_due
                    && (bits_left == 3'd0) && (bytes_left == '0);
    assign in_ready  = need_byte && !hs_mode;
    assign underrun  = in_ready && !in_valid;
    assign load_byte = need_byte && (hs_mode || in_valid);
    assign next_byte = hs_mode ? pid_byte : in_data;

    assign coder_step = tick && ((state == ST_LEAD)
                     || ((state == ST_DATA) && !pkt_done && !underrun));
    assign coder_bit  = (state == ST_LEAD)   ? SYNC_BYTE[0] :
                        (bits_left != 3'd0)  ? shreg[0]     : next_byte[0];

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)                  state_nx = ST_LEAD;
            ST_LEAD: if (tick)                   state_nx = ST_DATA;
            ST_DATA: if (pkt_done || underrun)   state_nx = ST_SE0;
            ST_SE0:  if (tick && se0_cnt == SE_W'(EOP_SE0_BITS - 1))
                                                 state_nx = ST_EOPJ;
            ST_EOPJ: if (tick)                   state_nx = ST_IDLE;
            default:                             state_nx = ST_IDLE;
        endcase
    end

    // state register and packet datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            pid_byte    <= '0;
            bits_left   <= '0;
            bytes_left  <= '0;
            se0_cnt     <= '0;
            hs_mode     <= 1'b0;
            tx_err      <= 1'b0;
            addr_commit <= 1'b0;
        end else begin
            state       <= state_nx;
            addr_commit <= (state == ST_EOPJ) && tick && !hs_mode && !tx_err;
            if (accept) begin
                hs_mode    <= hs_req;
                pid_byte   <= hs_nak ? PID_NAK : PID_ACK;
                bytes_left <= hs_req ? CNT_W'(1) :
                              (byte_cnt == '0) ? '0 : byte_cnt - 1'b1;
                tx_err     <= 1'b0;
                se0_cnt    <= '0;
            end
            if (state == ST_LEAD && tick) begin
                shreg     <= SYNC_BYTE >> 1;
                bits_left <= 3'd7;
            end
            if (state == ST_DATA && tick && !stuff_due) begin
                if (bits_left != 3'd0) begin
                    shreg     <= shreg >> 1;
                    bits_left <= bits_left - 3'd1;
                end else if (load_byte) begin
                    shreg      <= next_byte >> 1;
                    bits_left  <= 3'd7;
                    bytes_left <= bytes_left - 1'b1;
                end
            end
            if (underrun) tx_err <= 1'b1;
            if (state == ST_SE0 && tick) se0_cnt <= se0_cnt + 1'b1;
        end
    end

    // line outputs
    always_comb begin
        oe_o = 1'b1;
        dp_o = 1'b0;
        dm_o = 1'b1;
        unique case (state)
            ST_IDLE: begin oe_o = 1'b0; dm_o = 1'b0; end
            ST_LEAD, ST_EOPJ: ;
            ST_DATA: begin dp_o = level_k; dm_o = ~level_k; end
            ST_SE0:  dm_o = 1'b0;
            default: begin oe_o = 1'b0; dm_o = 1'b0; end
        endcase
        busy = (state != ST_IDLE);
    end

endmodule

// File: rtl/lsusb_tx_chk.sv
module lsusb_tx_chk #(
    parameter int PH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            oe_o,
    input logic            dp_o,
    input logic            dm_o,
    input logic            in_ready,
    input logic            in_valid,
    input logic            tx_err,
    input logic            addr_commit,
    input logic [PH_W-1:0] phase
);

    // R2
    lead_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && oe_o && !dp_o && dm_o));

    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && $past(oe_o) && phase != '0) |-> $stable({dp_o, dm_o}));

    // R4
    no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_o && dm_o));

    // R7
    ready_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && oe_o));

    // R12
    underrun_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (oe_o && !dp_o && !dm_o && tx_err));

    // R11
    commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_commit |-> (!oe_o && $past(oe_o)));

endmodule

bind lsusb_tx lsusb_tx_chk #(.PH_W(PH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .oe_o        (oe_o),
    .dp_o        (dp_o),
    .dm_o        (dm_o),
    .in_ready    (in_ready),
    .in_valid    (in_valid),
    .tx_err      (tx_err),
    .addr_commit (addr_commit),
    .phase       (bit_phase)
);

// File: tb/sim_lsusb_tx.sv
module sim_lsusb_tx;

    typedef struct packed {
        logic       hs;
        logic       nak;
        logic [1:0] n;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       commit;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 2'd3, 8'hFC, 8'h01, 8'h00, 1'b1},  // stuff meets byte fetch
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0},  // ACK
        '{1'b1, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0},  // NAK
        '{1'b0, 1'b0, 2'd2, 8'hA5, 8'hFC, 8'h00, 1'b1},  // stuff before EOP
        '{1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b1},  // sync only
        '{1'b0, 1'b0, 2'd3, 8'hC3, 8'hFF, 8'h00, 1'b1}   // long run of ones
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, hs_req = 1'b0, hs_nak = 1'b0;
    logic [7:0] byte_cnt = '0, in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready, dp_o, dm_o, oe_o, busy, tx_err, addr_commit;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [7:0] feed [3];
    int feed_n = 0, feed_idx = 0, taken = 0, rdy_cnt = 0, commits = 0;
    bit take_pend = 1'b0;

    logic [2:0] exp_s [80];   // {oe, dp, dm}
    int ns = 0;

    always #4 clk = ~clk;

    lsusb_tx u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .hs_req(hs_req), .hs_nak(hs_nak),
        .byte_cnt(byte_cnt), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy(busy), .tx_err(tx_err),
        .addr_commit(addr_commit)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // byte source and event counters
    initial forever begin
        @(negedge clk);
        if (take_pend) begin feed_idx++; taken++; end
        in_valid = (feed_idx < feed_n);
        in_data  = (feed_idx < 3) ? feed[feed_idx] : 8'h00;
        take_pend = in_ready && in_valid;
        if (in_ready) rdy_cnt++;
        if (addr_commit) commits++;
    end

    task automatic put(input logic oe, input logic dp, input logic dm);
        exp_s[ns] = {oe, dp, dm};
        ns++;
    endtask

    task automatic build(input logic hs, input logic nak, input int n,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] by [4];
        int nb, ones;
        logic lvl;
        by[0] = 8'h80;
        if (hs) begin by[1] = nak ? 8'h5A : 8'hD2; nb = 2; end
        else begin by[1] = b0; by[2] = b1; by[3] = b2; nb = n + 1; end
        ns = 0; ones = 0; lvl = 1'b0;
        put(1, 0, 1);
        for (int i = 0; i < nb; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (!by[i][j]) begin lvl = ~lvl; ones = 0; end
                else ones++;
                put(1, lvl, ~lvl);
                if (ones == 6) begin lvl = ~lvl; ones = 0; put(1, lvl, ~lvl); end
            end
        end
        put(1, 0, 0); put(1, 0, 0); put(1, 0, 1); put(0, 0, 0);
    endtask

    task automatic run_pkt(input vec_t v, input bit poke, input int feed_lim);
        int c0, nsent;
        string tag;
        bit abort;
        nsent = (int'(v.n) < feed_lim) ? int'(v.n) : feed_lim;
        abort = !v.hs && (feed_lim < int'(v.n));
        @(negedge clk); #1;
        feed[0] = v.b0; feed[1] = v.b1; feed[2] = v.b2;
        feed_n = feed_lim; feed_idx = 0; taken = 0; rdy_cnt = 0;
        hs_req = v.hs; hs_nak = v.nak; byte_cnt = 8'(v.n) + 8'd1;
        c0 = commits;
        build(v.hs, v.nak, v.hs ? 0 : nsent, v.b0, v.b1, v.b2);
        start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < ns; k++) begin
            if (k == 0) tag = "R2 lead J";
            else if (k == ns - 1) tag = "R10 release";
            else if (k >= ns - 4) tag = "R9 eop";
            else tag = v.hs ? "R8 handshake" : "R3/R4/R5 data";
            chk({oe_o, dp_o, dm_o} == exp_s[k], tag, {oe_o, dp_o, dm_o}, exp_s[k]);
            chk(busy == exp_s[k][2], "R10 busy", busy, exp_s[k][2]);
            if (poke && k == 3) begin
                start = 1'b1; hs_req = ~hs_req;   // R13 start while busy
            end
            repeat (8) begin @(negedge clk); start = 1'b0; end
        end
        chk((commits - c0) == ((v.commit && !abort) ? 1 : 0), "R11 commit",
            commits - c0, (v.commit && !abort) ? 1 : 0);
        chk(taken == (v.hs ? 0 : nsent), "R7 bytes taken", taken, v.hs ? 0 : nsent);
        if (v.hs) chk(rdy_cnt == 0, "R8 ready low", rdy_cnt, 0);
        chk(tx_err == abort, "R12 err flag", tx_err, abort);
        if (poke) chk(!oe_o && !busy, "R13 ignored start", {oe_o, busy}, 0);
    endtask

    initial begin
        vec_t u;
        repeat (3) @(negedge clk);
        chk({oe_o, dp_o, dm_o, busy, in_ready, tx_err, addr_commit} == 7'd0,
            "R1 in reset", {oe_o, dp_o, dm_o, busy, in_ready, tx_err, addr_commit}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({oe_o, dp_o, dm_o, busy, in_ready, tx_err, addr_commit} == 7'd0,
            "R1 after reset", {oe_o, dp_o, dm_o, busy, in_ready, tx_err, addr_commit}, 0);

        for (int i = 0; i < 6; i++) run_pkt(VECS[i], i == 0, int'(VECS[i].n));

        // R12: underrun after first data byte
        u = '{1'b0, 1'b0, 2'd2, 8'h00, 8'h00, 8'h00, 1'b1};
        run_pkt(u, 1'b0, 1);
        // next good packet clears the error flag (R12)
        run_pkt(VECS[1], 1'b0, 0);

        // R6: bit edge timing of the first coded bit
        @(negedge clk); #1;
        hs_req = 1'b1; hs_nak = 1'b0; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        repeat (8) @(negedge clk);
        chk({dp_o, dm_o} == 2'b01, "R6 last lead clock", {dp_o, dm_o}, 2'b01);
        @(negedge clk);
        chk({dp_o, dm_o} == 2'b10, "R6 first bit edge", {dp_o, dm_o}, 2'b10);
        for (int w = 0; w < 400 && busy; w++) @(negedge clk);
        chk(!busy && !oe_o, "R10 idle after packet", {busy, oe_o}, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule